// File: doc/BRIEF.md
# Tile Request Dispatcher

This block sits at the entrance of one compute tile and hands each incoming unit of work to a core in that tile. A work item is either a thread spawned by a running application or a data item that arrived through an external interface. Every core reports its current load as a small unsigned number. A rule table, written through a simple register-write port, says which cores may take each kind of work, how loaded a core may be and still accept more, which neighbouring tile takes the overflow, and at what total load the tile should ask for more resources.

The dispatch path has no register stage. While a request is offered, the block selects the least loaded core that the rules allow and whose load is under the limit, and it connects the request handshake straight to that core. When no core qualifies, the request goes to the named neighbour tile if forwarding is enabled. Otherwise it waits at the input with ready low, so no item is lost and the order is kept. When more cores are claimed, management software rewrites the enable masks, and excess work then flows to the new cores. A separate registered alarm watches the summed load of all cores and asks early for more cores. It has one count of hysteresis.

Top module: `tile_req_dispatch`

## Requirements
- R1: After reset both enable masks are zero, forwarding is disabled and the alarm threshold is all ones. An offered request therefore gets no core_valid, no fwd_valid and req_ready low, and load_alarm is low.
- R2: A core is eligible only if its bit in the enable mask for the request's kind is set and its load on core_load (core i in bits [i*LOAD_W +: LOAD_W]) is strictly below the programmed load limit.
- R3: Among eligible cores the one with the smallest load is selected. Ties go to the lowest core index.
- R4: In the same cycle, core_valid is one-hot on the selected core and equals req_valid, req_ready equals core_ready of the selected core, and core_data equals req_data. Which core is selected does not depend on core_ready.
- R5: req_src 0 (spawned thread) uses the mask at address 0. req_src 1 (external data) uses the mask at address 1.
- R6: With no eligible core and forwarding enabled (bit 0 of address 3), fwd_valid follows req_valid, req_ready equals fwd_ready, fwd_tile shows bits [2:1] of address 3, and no core_valid is raised.
- R7: With no eligible core and forwarding disabled, req_ready is low and neither core_valid nor fwd_valid is raised, so the request is held.
- R8: A write with cfg_we high takes effect from the clock edge that samples it. Address 2 holds the load limit in its low LOAD_W bits. Address 4 holds the alarm threshold in its low SUM_W bits.
- R9: load_alarm goes high on the edge after the summed core load exceeds the threshold.
- R10: Once high, load_alarm stays high while the sum equals the threshold. It clears on the edge after the sum drops below the threshold. From low, a sum equal to the threshold leaves it low.
- R11: A write to an address above 4 changes no rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle |
| req_src | input | 1 | 0 spawned thread, 1 external data |
| req_data | input | DATA_W | Request descriptor |
| core_load | input | NUM_CORES*LOAD_W | Load per core, core 0 lowest |
| core_valid | output | NUM_CORES | Request valid toward each core |
| core_ready | input | NUM_CORES | Core accepts |
| core_data | output | DATA_W | Descriptor toward cores |
| fwd_valid | output | 1 | Request forwarded to neighbour |
| fwd_ready | input | 1 | Neighbour accepts |
| fwd_data | output | DATA_W | Descriptor toward neighbour |
| fwd_tile | output | NB_W | Neighbour named by the rules |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | 3 | Rule address |
| cfg_wdata | input | CFG_W | Rule write data |
| load_alarm | output | 1 | Summed load over threshold |

## Verification
The selection path is tried with load patterns that have a single minimum, a minimum tied across several cores, cores knocked out only by the limit, and cores knocked out only by the mask. These cases separate a correct arg-min from a first-fit choice, from a choice that ignores the limit, and from one that reads the wrong mask for the request kind. Patterns where every core is excluded, tried with the neighbour ready, stalled and disabled, separate forwarding from holding. A core that is not ready while chosen shows that readiness does not steer the choice. Alarm sums are stepped across the threshold from both sides, which separates a hysteresis alarm from a plain comparator.

// File: rtl/td_pkg.sv
package td_pkg;

   typedef enum logic [2:0] {
      RA_THREAD_MASK = 3'd0,
      RA_DATA_MASK   = 3'd1,
      RA_LOAD_LIMIT  = 3'd2,
      RA_FORWARD     = 3'd3,
      RA_THRESHOLD   = 3'd4
   } rule_addr_e;

   typedef enum logic {
      KIND_THREAD = 1'b0,
      KIND_DATA   = 1'b1
   } req_kind_e;

endpackage

// File: rtl/td_rule_regs.sv
module td_rule_regs
   import td_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int LOAD_W    = 4,
   parameter int SUM_W     = 6,
   parameter int NB_W      = 2,
   parameter int CFG_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_addr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [NUM_CORES-1:0] thread_mask,
   output logic [NUM_CORES-1:0] data_mask,
   output logic [LOAD_W-1:0]    load_limit,
   output logic                 fwd_en,
   output logic [NB_W-1:0]      fwd_id,
   output logic [SUM_W-1:0]     threshold
);

   if (CFG_W < NUM_CORES) begin : g_chk_mask
      $error("CFG_W too narrow for core mask");
   end
   if (CFG_W < SUM_W) begin : g_chk_thr
      $error("CFG_W too narrow for threshold");
   end
   if (CFG_W < NB_W + 1) begin : g_chk_fwd
      $error("CFG_W too narrow for forward rule");
   end

   rule_addr_e addr_e;
   assign addr_e = rule_addr_e'(cfg_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thread_mask <= '0;
         data_mask   <= '0;
         load_limit  <= '1;
         fwd_en      <= 1'b0;
         fwd_id      <= '0;
         threshold   <= '1;
      end else if (cfg_we) begin
         case (addr_e)
            RA_THREAD_MASK: thread_mask <= cfg_wdata[NUM_CORES-1:0];
            RA_DATA_MASK:   data_mask   <= cfg_wdata[NUM_CORES-1:0];
            RA_LOAD_LIMIT:  load_limit  <= cfg_wdata[LOAD_W-1:0];
            RA_FORWARD: begin
               fwd_en <= cfg_wdata[0];
               fwd_id <= cfg_wdata[NB_W:1];
            end
            RA_THRESHOLD:   threshold   <= cfg_wdata[SUM_W-1:0];
            default: ;
         endcase
      end
   end

   // R8: a write lands on the following edge
   p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd0) |=> (thread_mask == $past(cfg_wdata[NUM_CORES-1:0])));

   // R11: unmapped addresses leave every rule untouched
   p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr > 3'd4) |=> ($stable(thread_mask) && $stable(data_mask)
                                       && $stable(load_limit) && $stable(fwd_en)
                                       && $stable(fwd_id) && $stable(threshold)));

endmodule

// File: rtl/td_core_select.sv
module td_core_select #(
   parameter int NUM_CORES = 4,
   parameter int LOAD_W    = 4,
   parameter int IDX_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES*LOAD_W-1:0] loads,
   input  logic [NUM_CORES-1:0]        mask,
   input  logic [LOAD_W-1:0]           limit,
   output logic                        sel_valid,
   output logic [IDX_W-1:0]            sel_idx
);

   logic [LOAD_W-1:0]    load_arr [NUM_CORES];
   logic [NUM_CORES-1:0] elig;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_unpack
      assign load_arr[i] = loads[i*LOAD_W +: LOAD_W];
      assign elig[i]     = mask[i] && (load_arr[i] < limit);
   end

   logic [LOAD_W-1:0] best_load;

   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      best_load = '1;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (elig[i] && (!sel_valid || load_arr[i] < best_load)) begin
            sel_valid = 1'b1;
            sel_idx   = IDX_W'(i);
            best_load = load_arr[i];
         end
      end
   end

   // R2: the chosen core is masked in and under the limit
   p_sel_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (mask[sel_idx] && loads[sel_idx*LOAD_W +: LOAD_W] < limit));

   for (genvar j = 0; j < NUM_CORES; j++) begin : g_min_chk
      // R3: no eligible core is strictly lighter than the chosen one
      p_sel_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid && mask[j] && loads[j*LOAD_W +: LOAD_W] < limit)
            |-> (loads[sel_idx*LOAD_W +: LOAD_W] <= loads[j*LOAD_W +: LOAD_W]));
      // R2: no eligible core is left unselected
      p_none_missed_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (mask[j] && loads[j*LOAD_W +: LOAD_W] < limit) |-> sel_valid);
   end

endmodule

// File: rtl/td_load_alarm.sv
module td_load_alarm #(
   parameter int NUM_CORES = 4,
   parameter int LOAD_W    = 4,
   parameter int SUM_W     = 6,
   parameter bit HYST_EN   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES*LOAD_W-1:0] loads,
   input  logic [SUM_W-1:0]            threshold,
   output logic                        alarm
);

   logic [SUM_W-1:0] total;

   always_comb begin
      total = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         total = total + SUM_W'(loads[i*LOAD_W +: LOAD_W]);
      end
   end

   logic alarm_d;

   if (HYST_EN) begin : g_hyst
      always_comb begin
         if (total > threshold)      alarm_d = 1'b1;
         else if (total < threshold) alarm_d = 1'b0;
         else                        alarm_d = alarm;
      end
   end else begin : g_plain
      assign alarm_d = (total > threshold);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alarm <= 1'b0;
      else        alarm <= alarm_d;
   end

   // R9: the alarm only rises after an over-threshold sum
   p_alarm_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm) |-> $past(total > threshold));

   // R10: with hysteresis the alarm only falls after a below-threshold sum
   if (HYST_EN) begin : g_fall_chk
      p_alarm_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(alarm) |-> $past(total < threshold));
   end

endmodule

// File: rtl/tile_req_dispatch.sv
module tile_req_dispatch
   import td_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int LOAD_W    = 4,
   parameter int DATA_W    = 16,
   parameter int NB_W      = 2,
   parameter int CFG_W     = 16,
   parameter bit HYST_EN   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_src,
   input  logic [DATA_W-1:0]           req_data,
   input  logic [NUM_CORES*LOAD_W-1:0] core_load,
   output logic [NUM_CORES-1:0]        core_valid,
   input  logic [NUM_CORES-1:0]        core_ready,
   output logic [DATA_W-1:0]           core_data,
   output logic                        fwd_valid,
   input  logic                        fwd_ready,
   output logic [DATA_W-1:0]           fwd_data,
   output logic [NB_W-1:0]             fwd_tile,
   input  logic                        cfg_we,
   input  logic [2:0]                  cfg_addr,
   input  logic [CFG_W-1:0]            cfg_wdata,
   output logic                        load_alarm
);

   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int SUM_W = LOAD_W + ((NUM_CORES > 1) ? $clog2(NUM_CORES) : 0) + 1;

   if (NUM_CORES < 1) begin : g_chk_cores
      $error("NUM_CORES must be at least one");
   end
   if (LOAD_W < 1 || DATA_W < 1 || NB_W < 1) begin : g_chk_widths
      $error("widths must be positive");
   end

   logic [NUM_CORES-1:0] thread_mask, data_mask, act_mask;
   logic [LOAD_W-1:0]    load_limit;
   logic                 fwd_en;
   logic [NB_W-1:0]      fwd_id;
   logic [SUM_W-1:0]     threshold;

   td_rule_regs #(
      .NUM_CORES(NUM_CORES), .LOAD_W(LOAD_W), .SUM_W(SUM_W),
      .NB_W(NB_W), .CFG_W(CFG_W)
   ) u_rules (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .thread_mask(thread_mask), .data_mask(data_mask),
      .load_limit(load_limit), .fwd_en(fwd_en), .fwd_id(fwd_id),
      .threshold(threshold)
   );

   assign act_mask = (req_kind_e'(req_src) == KIND_DATA) ? data_mask : thread_mask;

   logic             sel_valid;
   logic [IDX_W-1:0] sel_idx;

   td_core_select #(
      .NUM_CORES(NUM_CORES), .LOAD_W(LOAD_W), .IDX_W(IDX_W)
   ) u_select (
      .clk(clk), .rst_n(rst_n),
      .loads(core_load), .mask(act_mask), .limit(load_limit),
      .sel_valid(sel_valid), .sel_idx(sel_idx)
   );

   td_load_alarm #(
      .NUM_CORES(NUM_CORES), .LOAD_W(LOAD_W), .SUM_W(SUM_W), .HYST_EN(HYST_EN)
   ) u_alarm (
      .clk(clk), .rst_n(rst_n),
      .loads(core_load), .threshold(threshold), .alarm(load_alarm)
   );

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core_out
      assign core_valid[i] = req_valid && sel_valid && (sel_idx == IDX_W'(i));
   end

   assign core_data = req_data;
   assign fwd_data  = req_data;
   assign fwd_tile  = fwd_id;
   assign fwd_valid = req_valid && !sel_valid && fwd_en;

   always_comb begin
      if (sel_valid)   req_ready = core_ready[sel_idx];
      else if (fwd_en) req_ready = fwd_ready;
      else             req_ready = 1'b0;
   end

   // R4: at most one core is offered the request
   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_valid));

   // R6: a request never goes both to a core and to the neighbour
   p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !((|core_valid) && fwd_valid));

   // R7: a taken request was offered to exactly one destination
   p_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> ($countones({core_valid, fwd_valid}) == 1));

endmodule

// File: tb/tile_req_dispatch_bench.sv
module tile_req_dispatch_bench;

   localparam int N  = 4;
   localparam int LW = 4;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_src = 1'b0;
   logic [DW-1:0] req_data = '0;
   logic [N*LW-1:0] core_load = '0;
   logic [N-1:0]  core_valid;
   logic [N-1:0]  core_ready = '1;
   logic [DW-1:0] core_data;
   logic          fwd_valid;
   logic          fwd_ready = 1'b1;
   logic [DW-1:0] fwd_data;
   logic [1:0]    fwd_tile;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [15:0]   cfg_wdata = '0;
   logic          load_alarm;

   int applied = 0;
   int miscompares = 0;

   always #10 clk = ~clk;

   tile_req_dispatch u_tile_req_dispatch (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
      .req_data(req_data), .core_load(core_load),
      .core_valid(core_valid), .core_ready(core_ready), .core_data(core_data),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
      .fwd_tile(fwd_tile), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .load_alarm(load_alarm)
   );

   // {src, loads, core_ready, fwd_ready, exp core_valid, exp fwd_valid, exp req_ready}
   localparam logic [27:0] VEC [10] = '{
      {1'b0, 16'h7253, 4'hF,    1'b1, 4'b0100, 1'b0, 1'b1},
      {1'b0, 16'h3533, 4'hF,    1'b1, 4'b0001, 1'b0, 1'b1},
      {1'b0, 16'h9ABC, 4'hF,    1'b1, 4'b1000, 1'b0, 1'b1},
      {1'b0, 16'hABCD, 4'hF,    1'b1, 4'b0000, 1'b1, 1'b1},
      {1'b0, 16'hABCD, 4'hF,    1'b0, 4'b0000, 1'b1, 1'b0},
      {1'b1, 16'h5501, 4'hF,    1'b1, 4'b0100, 1'b0, 1'b1},
      {1'b1, 16'hA901, 4'hF,    1'b1, 4'b0100, 1'b0, 1'b1},
      {1'b1, 16'hAB00, 4'hF,    1'b1, 4'b0000, 1'b1, 1'b1},
      {1'b0, 16'h7253, 4'b1011, 1'b1, 4'b0100, 1'b0, 1'b0},
      {1'b0, 16'h0000, 4'hF,    1'b1, 4'b0001, 1'b0, 1'b1}
   };
   string vec_tag [10] = '{"R3", "R3", "R2", "R6", "R6", "R5", "R2", "R5", "R4", "R3"};

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      applied++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_out(input string tag, input logic [3:0] cv, input logic fv,
                             input logic rdy);
      #2;
      check({core_valid, fv ^ fwd_valid, rdy ^ req_ready} == {cv, 1'b0, 1'b0}, tag,
            {26'd0, core_valid, fwd_valid, req_ready}, {26'd0, cv, fv, rdy});
   endtask

   initial begin
      #4_000_000;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req_valid = 1'b1; req_data = 16'hBEEF; core_load = '0;
      // R1: reset rules leave a request held and the alarm low
      expect_out("R1", 4'b0000, 1'b0, 1'b0);
      check(load_alarm == 1'b0, "R1", {31'd0, load_alarm}, 32'd0);

      wr(3'd0, 16'h000F);            // thread mask: all cores
      wr(3'd1, 16'h000C);            // data mask: cores 2 and 3
      wr(3'd2, 16'd10);              // load limit
      wr(3'd3, 16'h0005);            // forward on, neighbour 2

      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         req_src    = VEC[v][27];
         core_load  = VEC[v][26:11];
         core_ready = VEC[v][10:7];
         fwd_ready  = VEC[v][6];
         req_data   = 16'(16'h1000 + v);
         expect_out(vec_tag[v], VEC[v][5:2], VEC[v][1], VEC[v][0]);
         if (VEC[v][5:2] != 0)
            check(core_data == req_data, "R4", {16'd0, core_data}, {16'd0, req_data});
         if (VEC[v][1])
            check(fwd_tile == 2'd2 && fwd_data == req_data, "R6",
                  {14'd0, fwd_tile, fwd_data}, {14'd0, 2'd2, req_data});
      end

      // R4: no offer while req_valid is low
      @(negedge clk);
      core_ready = '1; fwd_ready = 1'b1; req_src = 1'b0; core_load = 16'h7253;
      req_valid = 1'b0;
      expect_out("R4", 4'b0000, 1'b0, 1'b1);
      req_valid = 1'b1;

      // R8: rewritten mask steers to the one claimed core
      core_load = 16'h0005;
      wr(3'd0, 16'h0001);
      expect_out("R8", 4'b0001, 1'b0, 1'b1);

      // R11: write to an unmapped address changes nothing
      wr(3'd7, 16'h0000);
      expect_out("R11", 4'b0001, 1'b0, 1'b1);

      // R7: nothing eligible and forwarding off holds the request
      wr(3'd3, 16'h0000);
      core_load = 16'hFFFF;
      expect_out("R7", 4'b0000, 1'b0, 1'b0);

      // R9 / R10: alarm threshold 20 with hysteresis
      wr(3'd4, 16'd20);
      core_load = 16'h5555;          // sum 20 from low: stays low
      @(negedge clk); #2;
      check(load_alarm == 1'b0, "R10", {31'd0, load_alarm}, 32'd0);
      core_load = 16'h5556;          // sum 21
      @(negedge clk); #2;
      check(load_alarm == 1'b1, "R9", {31'd0, load_alarm}, 32'd1);
      core_load = 16'h5555;          // sum 20: held high
      @(negedge clk); #2;
      check(load_alarm == 1'b1, "R10", {31'd0, load_alarm}, 32'd1);
      core_load = 16'h5554;          // sum 19: clears
      @(negedge clk); #2;
      check(load_alarm == 1'b0, "R10", {31'd0, load_alarm}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

endmodule